// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Bank

This block is the software-visible register bank placed in front of an address-translation table walker. It stores, for each of up to sixteen traffic streams, a mode word (translate enable plus two bypass controls) and four table base words, together with a mask of enabled streams and a stream-select mask. Software reaches all of it through a simple 32-bit register port. Writes take effect on the clock edge, and read data follows the address combinationally.

The walker reports translation faults as single-cycle events that carry a stream number, a 24-bit fault code and the faulting address. The bank captures the first such fault and keeps it until software clears it by writing all ones. Software can also issue a stream invalidation. A command write snapshots the select mask and raises a request towards the downstream caches. A busy bit in the command register then reads as one until the downstream acknowledge arrives, and software polls that bit. A sticky lock bit freezes the mode and base words once software has finished configuration.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset every mapped register reads zero and `invReq` is low. A later reset returns the lock bit, the mode words and the base words to zero.
- R2: The select mask sits at 0x034 and the enabled mask at 0x0FC; each keeps only its low NUM_STREAMS bits. The mode word of stream s is at 0x100+4*s and keeps only bit 7 (translate), bit 8 (bypass) and bit 12 (alternate bypass). Base word i (0..3) of stream s is at 0x200+16*s+4*i and keeps all 32 bits.
- R3: An unaligned offset, or one that is not in the map, reads as zero and ignores writes.
- R4: When a fault event arrives while the fault flag is clear, 0x040 reads the following from the next cycle: bit 31 set, the stream in bits 27:24 and the code in bits 23:0. At the same time 0x050 holds address bits 31:0 and 0x054 holds the address bits above 31, zero-extended.
- R5: While the fault flag is set, further fault events leave 0x040, 0x050 and 0x054 unchanged.
- R6: Writing exactly 0xFFFFFFFF to 0x040 clears the fault flag, stream, code and address to zero. Any other value written there has no effect.
- R7: A fault event in the same cycle as a clearing write is captured, not lost.
- R8: A write to 0x020 with bit 20 set, made while idle, raises `invReq` on the next cycle. `invMask` then equals the select mask as it stood at that write, and bit 2 of 0x020 reads one. A write to 0x020 without bit 20 starts nothing.
- R9: `invReq` and `invMask` hold until `invAck` is sampled high. From the following cycle `invReq` is low and bit 2 of 0x020 reads zero. Changing the select mask while busy does not alter `invMask`.
- R10: A start command written while an invalidation is pending is ignored and yields no second request.
- R11: Writing bit 15 of 0x060 sets a lock that reads back in bit 15 and is cleared only by reset. While it is set, writes to mode and base words are ignored, and the select and enabled masks stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| faultValid | input | 1 | Fault event from the walker, one cycle |
| faultStream | input | 4 | Stream of the fault event |
| faultCode | input | 24 | Fault code of the event |
| faultAddr | input | FLT_ADDR_W | Faulting address |
| invReq | output | 1 | Invalidation request, held until acknowledged |
| invMask | output | NUM_STREAMS | Streams affected by the pending invalidation |
| invAck | input | 1 | Invalidation complete, one cycle |

## Verification
The assertions assume that the downstream side raises `invAck` only while `invReq` is high, and for a single cycle. The bench pulses the acknowledge once per request and only after it has seen the request. The fault inputs are treated as free-running events that may coincide with any register write. The bench therefore drives one such event in the same cycle as a clearing write. It changes inputs only on falling edges, one write per two-cycle access.

// File: rtl/xlat_ctrl_pkg.sv
package xlat_ctrl_pkg;
  localparam int DATA_W = 32;
  localparam int STRM_W = 4;
  localparam int SLOT_W = 2;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int CODE_W = 24;

  localparam int BIT_XLAT   = 7;
  localparam int BIT_BYP    = 8;
  localparam int BIT_BYPALT = 12;
  localparam int BIT_BUSY   = 2;
  localparam int BIT_GO     = 20;
  localparam int BIT_LOCK   = 15;
  localparam int BIT_FLAG   = 31;

  typedef enum logic [3:0] {
    RD_NONE, RD_CMD, RD_SEL, RD_FLT, RD_FA_LO, RD_FA_HI,
    RD_CFG, RD_ENA, RD_MODE, RD_BASE
  } rd_sel_e;

  typedef enum logic {INV_IDLE, INV_WAIT} inv_state_e;

  typedef struct packed {
    logic xlatEn;
    logic bypass;
    logic bypassAlt;
  } mode_t;

  typedef struct packed {
    logic              wrSel;
    logic              wrEna;
    logic              wrCfg;
    logic              wrMode;
    logic              wrBase;
    logic              fltClr;
    logic              invStart;
    logic [STRM_W-1:0] strmIdx;
    logic [SLOT_W-1:0] slotIdx;
    rd_sel_e           rdSel;
  } strb_t;
endpackage

// File: rtl/xlat_ctrl_ctl.sv
module xlat_ctrl_ctl
  import xlat_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_STREAMS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              lockBit,
  input  logic              invAck,
  output strb_t             strb,
  output logic              busy
);
  localparam logic [31:0] OFF_CMD  = 32'h020;
  localparam logic [31:0] OFF_SEL  = 32'h034;
  localparam logic [31:0] OFF_FLT  = 32'h040;
  localparam logic [31:0] OFF_FALO = 32'h050;
  localparam logic [31:0] OFF_FAHI = 32'h054;
  localparam logic [31:0] OFF_CFG  = 32'h060;
  localparam logic [31:0] OFF_ENA  = 32'h0FC;
  localparam logic [31:0] MODE_LO  = 32'h100;
  localparam logic [31:0] MODE_HI  = MODE_LO + 32'(4 * NUM_STREAMS);
  localparam logic [31:0] BASE_LO  = 32'h200;
  localparam logic [31:0] BASE_HI  = BASE_LO + 32'(4 * SLOTS * NUM_STREAMS);

  logic [31:0]       addrW;
  rd_sel_e           sel;
  logic [STRM_W-1:0] strmIdx;
  logic [SLOT_W-1:0] slotIdx;
  inv_state_e        invState;

  assign addrW = 32'(regAddr);

  // address decode: one target per aligned mapped offset
  always_comb begin
    sel     = RD_NONE;
    strmIdx = '0;
    slotIdx = '0;
    if (regAddr[1:0] == 2'b00) begin
      if (addrW == OFF_CMD)       sel = RD_CMD;
      else if (addrW == OFF_SEL)  sel = RD_SEL;
      else if (addrW == OFF_FLT)  sel = RD_FLT;
      else if (addrW == OFF_FALO) sel = RD_FA_LO;
      else if (addrW == OFF_FAHI) sel = RD_FA_HI;
      else if (addrW == OFF_CFG)  sel = RD_CFG;
      else if (addrW == OFF_ENA)  sel = RD_ENA;
      else if (addrW >= MODE_LO && addrW < MODE_HI) begin
        sel     = RD_MODE;
        strmIdx = regAddr[2 +: STRM_W];
      end else if (addrW >= BASE_LO && addrW < BASE_HI) begin
        sel     = RD_BASE;
        strmIdx = regAddr[2 + SLOT_W +: STRM_W];
        slotIdx = regAddr[2 +: SLOT_W];
      end
    end
  end

  assign busy = (invState == INV_WAIT);

  always_comb begin
    strb          = '0;
    strb.rdSel    = sel;
    strb.strmIdx  = strmIdx;
    strb.slotIdx  = slotIdx;
    strb.wrSel    = regWrEn && (sel == RD_SEL);
    strb.wrEna    = regWrEn && (sel == RD_ENA);
    strb.wrCfg    = regWrEn && (sel == RD_CFG);
    strb.wrMode   = regWrEn && (sel == RD_MODE) && !lockBit;
    strb.wrBase   = regWrEn && (sel == RD_BASE) && !lockBit;
    strb.fltClr   = regWrEn && (sel == RD_FLT) && (regWrData == '1);
    strb.invStart = regWrEn && (sel == RD_CMD) && regWrData[BIT_GO] && !busy;
  end

  // invalidation sequencer: idle until started, waits for the acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invState <= INV_IDLE;
    end else begin
      unique case (invState)
        INV_IDLE: if (strb.invStart) invState <= INV_WAIT;
        INV_WAIT: if (invAck)        invState <= INV_IDLE;
        default:                     invState <= INV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_ctrl_dp.sv
module xlat_ctrl_dp
  import xlat_ctrl_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int FLT_ADDR_W  = 48
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strb_t                  strb,
  input  logic                   busy,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic                   faultValid,
  input  logic [STRM_W-1:0]      faultStream,
  input  logic [CODE_W-1:0]      faultCode,
  input  logic [FLT_ADDR_W-1:0]  faultAddr,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   lockBit,
  output logic                   fltFlag,
  output logic [NUM_STREAMS-1:0] invMask
);
  localparam int HI_W = FLT_ADDR_W - 32;

  logic [NUM_STREAMS-1:0] selMask;
  logic [NUM_STREAMS-1:0] enaMask;
  logic [STRM_W-1:0]      fltStrm;
  logic [CODE_W-1:0]      fltCode;
  logic [FLT_ADDR_W-1:0]  fltAddr;
  logic                   capture;
  mode_t                  modeArr [NUM_STREAMS];
  logic [DATA_W-1:0]      baseArr [NUM_STREAMS][SLOTS];

  // stream-wide masks and lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selMask <= '0;
      enaMask <= '0;
      invMask <= '0;
      lockBit <= 1'b0;
    end else begin
      if (strb.wrSel)    selMask <= regWrData[NUM_STREAMS-1:0];
      if (strb.wrEna)    enaMask <= regWrData[NUM_STREAMS-1:0];
      if (strb.invStart) invMask <= selMask;
      if (strb.wrCfg && regWrData[BIT_LOCK]) lockBit <= 1'b1;
    end
  end

  // first-fault capture; a clear in the same cycle lets the new fault in
  assign capture = faultValid && (!fltFlag || strb.fltClr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fltFlag <= 1'b0;
      fltStrm <= '0;
      fltCode <= '0;
      fltAddr <= '0;
    end else if (capture) begin
      fltFlag <= 1'b1;
      fltStrm <= faultStream;
      fltCode <= faultCode;
      fltAddr <= faultAddr;
    end else if (strb.fltClr) begin
      fltFlag <= 1'b0;
      fltStrm <= '0;
      fltCode <= '0;
      fltAddr <= '0;
    end
  end

  // per-stream mode and base storage
  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeArr[s] <= '0;
      end else if (strb.wrMode && strb.strmIdx == STRM_W'(s)) begin
        modeArr[s] <= '{xlatEn:    regWrData[BIT_XLAT],
                        bypass:    regWrData[BIT_BYP],
                        bypassAlt: regWrData[BIT_BYPALT]};
      end
    end
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseArr[s][k] <= '0;
        end else if (strb.wrBase && strb.strmIdx == STRM_W'(s)
                     && strb.slotIdx == SLOT_W'(k)) begin
          baseArr[s][k] <= regWrData;
        end
      end
    end
  end

  // read mux
  always_comb begin
    mode_t m;
    m         = modeArr[strb.strmIdx];
    regRdData = '0;
    unique case (strb.rdSel)
      RD_CMD:   regRdData[BIT_BUSY] = busy;
      RD_SEL:   regRdData = DATA_W'(selMask);
      RD_ENA:   regRdData = DATA_W'(enaMask);
      RD_FLT:   begin
        regRdData[BIT_FLAG]     = fltFlag;
        regRdData[27:24]        = fltStrm;
        regRdData[CODE_W-1:0]   = fltCode;
      end
      RD_FA_LO: regRdData = fltAddr[31:0];
      RD_FA_HI: regRdData = DATA_W'(fltAddr[32 +: HI_W]);
      RD_CFG:   regRdData[BIT_LOCK] = lockBit;
      RD_MODE:  begin
        regRdData[BIT_XLAT]   = m.xlatEn;
        regRdData[BIT_BYP]    = m.bypass;
        regRdData[BIT_BYPALT] = m.bypassAlt;
      end
      RD_BASE:  regRdData = baseArr[strb.strmIdx][strb.slotIdx];
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_ctrl_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int ADDR_W      = 12,
  parameter int FLT_ADDR_W  = 48
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWrEn,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic                   faultValid,
  input  logic [3:0]             faultStream,
  input  logic [23:0]            faultCode,
  input  logic [FLT_ADDR_W-1:0]  faultAddr,
  output logic                   invReq,
  output logic [NUM_STREAMS-1:0] invMask,
  input  logic                   invAck
);
  strb_t strb;
  logic  busy;
  logic  lockBit;
  logic  fltFlag;

  xlat_ctrl_ctl #(.ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .lockBit(lockBit), .invAck(invAck),
    .strb(strb), .busy(busy)
  );

  xlat_ctrl_dp #(.NUM_STREAMS(NUM_STREAMS), .FLT_ADDR_W(FLT_ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .regWrData(regWrData),
    .faultValid(faultValid), .faultStream(faultStream), .faultCode(faultCode),
    .faultAddr(faultAddr), .regRdData(regRdData), .lockBit(lockBit),
    .fltFlag(fltFlag), .invMask(invMask)
  );

  assign invReq = busy;
endmodule

// File: rtl/xlat_ctrl_chk.sv
module xlat_ctrl_chk #(
  parameter int NUM_STREAMS = 16,
  parameter int ADDR_W      = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      regAddr,
  input logic                   regWrEn,
  input logic [31:0]            regWrData,
  input logic                   faultValid,
  input logic                   invReq,
  input logic                   invAck,
  input logic [NUM_STREAMS-1:0] invMask,
  input logic                   fltFlag,
  input logic                   lockBit
);
  logic clrWr;
  logic goWr;
  assign clrWr = regWrEn && regAddr == ADDR_W'('h40) && regWrData == 32'hFFFF_FFFF;
  assign goWr  = regWrEn && regAddr == ADDR_W'('h20) && regWrData[20];

  // input assumption: acknowledge only answers a pending request (R9)
  p_ack_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    invAck |-> invReq);

  p_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    goWr && !invReq |=> invReq);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    invReq && !invAck |=> invReq);

  p_mask_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    invReq && !invAck |=> $stable(invMask));

  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    invReq && invAck |=> !invReq);

  p_fault_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> fltFlag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    fltFlag && !clrWr |=> fltFlag);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    lockBit |=> lockBit);
endmodule

bind xlat_ctrl_regs xlat_ctrl_chk #(.NUM_STREAMS(NUM_STREAMS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xlat_ctrl_regs_bench.sv
module xlat_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        faultValid = 1'b0;
  logic [3:0]  faultStream = '0;
  logic [23:0] faultCode = '0;
  logic [47:0] faultAddr = '0;
  logic        invReq;
  logic [NS-1:0] invMask;
  logic        invAck = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctrl_regs u_xlat_ctrl_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .faultValid(faultValid),
    .faultStream(faultStream), .faultCode(faultCode), .faultAddr(faultAddr),
    .invReq(invReq), .invMask(invMask), .invAck(invAck)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic fault(input logic [3:0] s, input logic [23:0] c, input logic [47:0] ad);
    @(negedge clk);
    faultValid = 1'b1; faultStream = s; faultCode = c; faultAddr = ad;
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    rdChk("R1 cmd", 12'h020, 0);
    rdChk("R1 flt", 12'h040, 0);
    rdChk("R1 cfg", 12'h060, 0);
    rdChk("R1 ena", 12'h0FC, 0);
    rdChk("R1 mode", 12'h100, 0);
    rdChk("R1 base", 12'h200, 0);
    chk("R1 invReq", 32'(invReq), 0);
  endtask

  task automatic tMap();
    wr(12'h10C, 32'hFFFF_FFFF);
    rdChk("R2 mode s3 bits", 12'h10C, 32'h0000_1180);
    wr(12'h100, 32'h0000_0080);
    rdChk("R2 mode s0", 12'h100, 32'h0000_0080);
    rdChk("R2 mode s3 kept", 12'h10C, 32'h0000_1180);
    wr(12'h2FC, 32'hCAFE_F00D);
    wr(12'h2F8, 32'h1234_5678);
    wr(12'h214, 32'h0BAD_BEEF);
    rdChk("R2 base s15 i3", 12'h2FC, 32'hCAFE_F00D);
    rdChk("R2 base s15 i2", 12'h2F8, 32'h1234_5678);
    rdChk("R2 base s1 i1", 12'h214, 32'h0BAD_BEEF);
    wr(12'h0FC, 32'hFFFF_FFFF);
    rdChk("R2 ena width", 12'h0FC, 32'h0000_FFFF);
    wr(12'h034, 32'hFFFF_1234);
    rdChk("R2 sel width", 12'h034, 32'h0000_1234);
  endtask

  task automatic tUnmapped();
    wr(12'h044, 32'hDEAD_BEEF);
    rdChk("R3 hole", 12'h044, 0);
    wr(12'h102, 32'h0000_1000);
    rdChk("R3 unaligned rd", 12'h102, 0);
    rdChk("R3 unaligned no alias", 12'h100, 32'h0000_0080);
    rdChk("R3 past modes", 12'h140, 0);
    wr(12'h300, 32'h5555_5555);
    rdChk("R3 past bases", 12'h300, 0);
  endtask

  task automatic tFault();
    fault(4'd9, 24'h00ABCD, 48'h1234_89AB_CDEF);
    rdChk("R4 status", 12'h040, 32'h8900_ABCD);
    rdChk("R4 addr lo", 12'h050, 32'h89AB_CDEF);
    rdChk("R4 addr hi", 12'h054, 32'h0000_1234);
    fault(4'd2, 24'h000001, 48'h0000_0000_5555);
    rdChk("R5 status kept", 12'h040, 32'h8900_ABCD);
    rdChk("R5 addr kept", 12'h050, 32'h89AB_CDEF);
    wr(12'h040, 32'h7FFF_FFFF);
    rdChk("R6 partial ignored", 12'h040, 32'h8900_ABCD);
    wr(12'h040, 32'hFFFF_FFFF);
    rdChk("R6 cleared", 12'h040, 0);
    rdChk("R6 addr lo cleared", 12'h050, 0);
    rdChk("R6 addr hi cleared", 12'h054, 0);
  endtask

  task automatic tClearRace();
    fault(4'd1, 24'h000010, 48'h1);
    @(negedge clk);
    regAddr = 12'h040; regWrData = 32'hFFFF_FFFF; regWrEn = 1'b1;
    faultValid = 1'b1; faultStream = 4'd14; faultCode = 24'h000022;
    faultAddr = 48'h0000_AAAA_0000;
    @(negedge clk);
    regWrEn = 1'b0; faultValid = 1'b0;
    rdChk("R7 status", 12'h040, 32'h8E00_0022);
    rdChk("R7 addr", 12'h050, 32'hAAAA_0000);
    wr(12'h040, 32'hFFFF_FFFF);
  endtask

  task automatic tInval();
    wr(12'h020, 32'h0000_0004);
    chk("R8 no go bit", 32'(invReq), 0);
    wr(12'h034, 32'h0000_00A5);
    wr(12'h020, 32'h0010_0000);
    chk("R8 req", 32'(invReq), 1);
    chk("R8 mask", 32'(invMask), 32'h00A5);
    rdChk("R8 busy", 12'h020, 32'h0000_0004);
    wr(12'h034, 32'h0000_FFFF);
    chk("R9 mask frozen", 32'(invMask), 32'h00A5);
    repeat (3) @(negedge clk);
    chk("R9 req held", 32'(invReq), 1);
    wr(12'h020, 32'h0010_0000);
    @(negedge clk); invAck = 1'b1;
    @(negedge clk); invAck = 1'b0;
    chk("R9 req dropped", 32'(invReq), 0);
    rdChk("R9 busy clear", 12'h020, 0);
    repeat (2) @(negedge clk);
    chk("R10 no second req", 32'(invReq), 0);
    wr(12'h020, 32'h0010_0000);
    chk("R8 restart mask", 32'(invMask), 32'hFFFF);
    @(negedge clk); invAck = 1'b1;
    @(negedge clk); invAck = 1'b0;
  endtask

  task automatic tLock();
    wr(12'h060, 32'h0000_8000);
    rdChk("R11 lock read", 12'h060, 32'h0000_8000);
    wr(12'h10C, 32'h0);
    rdChk("R11 mode frozen", 12'h10C, 32'h0000_1180);
    wr(12'h2FC, 32'h0);
    rdChk("R11 base frozen", 12'h2FC, 32'hCAFE_F00D);
    wr(12'h034, 32'h3);
    rdChk("R11 sel writable", 12'h034, 32'h3);
    wr(12'h0FC, 32'h1);
    rdChk("R11 ena writable", 12'h0FC, 32'h1);
    wr(12'h060, 32'h0);
    rdChk("R11 lock sticky", 12'h060, 32'h0000_8000);
    doReset();
    rdChk("R1 lock reset", 12'h060, 0);
    rdChk("R1 mode reset", 12'h10C, 0);
    rdChk("R1 base reset", 12'h2FC, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMap();
    tUnmapped();
    tFault();
    tClearRace();
    tInval();
    tLock();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule